// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block manages a shared packet buffer divided into 256-byte pages, on behalf of both the transmit and the receive paths. A host issues 8-bit command words; the opcode lives in the top three bits. An allocation asks for a number of pages and is answered, one cycle later, with a packet number or a failure flag. Each live packet remembers how many pages it holds, so freeing it gives exactly those pages back to the pool.

Two small queues of packet numbers sit beside the pool. The receive queue is filled by a completion port that stands in for the receive MAC. The transmit queue is filled by host enqueue commands and drained by a completion strobe that stands in for the transmit MAC. Both queue heads and their empty flags are shown in one 16-bit view word. A separate word reports the free and total page counts. Commands that free pages hold a busy flag for a fixed number of cycles, and the block ignores commands while that flag is up.

Top module: `pkt_page_alloc`

## Requirements
- R1: After rst, mem_info reads {NUM_PAGES, NUM_PAGES}, queue_view reads 0x8080, alloc_result reads 0x00 and cmd_status bit 0 (busy) is low.
- R2: The opcode is cmd_word[7:5] (0 no-op, 1 allocate, 2 reset, 3 drop receive head, 4 release receive head, 5 free named packet, 6 enqueue for transmit, 7 reset transmit queue). An allocate requests cmd_word[3:0]+1 pages. On success, alloc_done pulses in the cycle after acceptance, alloc_result[6:0] holds the lowest unused packet number, bit 7 is 0, and the free count drops by the request.
- R3: An allocate fails when the free count is below the request or every packet slot is in use. alloc_result then reads 0x80 and the free count is unchanged, and alloc_done still pulses.
- R4: mem_info[15:8] is the current free page count and mem_info[7:0] is NUM_PAGES. A request for more pages than NUM_PAGES always fails.
- R5: queue_view[15] flags an empty receive queue, [14:8] is the receive head, [7] flags an empty transmit queue and [6:0] is the transmit head. A head field reads 0 when its queue is empty.
- R6: Enqueue (opcode 6) appends pkt_sel to the transmit queue, and tx_done removes its head. Entries come out in first-in first-out order, and a push into a full queue (depth Q_DEPTH) is dropped.
- R7: rx_done_valid appends rx_done_pkt to the receive queue. Opcode 3 removes the receive head without returning any pages.
- R8: Opcode 4 removes the receive head and returns its recorded pages. Opcode 5 returns the pages recorded for pkt_sel. Freeing a number that is not allocated changes nothing.
- R9: Opcodes 4 and 5 raise cmd_status[0] for REL_CYCLES cycles starting the cycle after acceptance. A command presented while busy is ignored.
- R10: Opcode 7 empties the transmit queue and leaves the receive queue and the pool untouched.
- R11: Opcode 2 returns all pages, frees every packet slot, empties both queues and clears alloc_result, including its fail bit.
- R12: Opcode 0 changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word present this cycle |
| cmd_word | input | 8 | Opcode in [7:5], page request minus one in [3:0] |
| pkt_sel | input | 7 | Packet number used by free and enqueue |
| cmd_status | output | 8 | Bit 0 is busy; other bits read 0 |
| alloc_result | output | 8 | Bit 7 fail, bits 6:0 packet number |
| alloc_done | output | 1 | One-cycle pulse when an allocation is answered |
| queue_view | output | 16 | Queue heads and empty flags |
| mem_info | output | 16 | Free pages in the high byte, total pages in the low byte |
| rx_done_valid | input | 1 | Receive completion: push a packet number |
| rx_done_pkt | input | 7 | Packet number to push on receive |
| tx_done | input | 1 | Transmit completion: pop the transmit head |

## Verification
The bench uses the default parameters: 12 pages, 4 packet slots, transmit and receive queues 4 deep, a 4-cycle release window and a 4-bit request field. With these values a 16-page request is beyond the pool, and the slots run out while 4 pages are still free, so the slot limit and the page limit each cause a failure on their own. A fifth enqueue overflows the transmit queue, and the whole pool can be drained to zero and then refilled after a reset.

// File: rtl/pba_pkg.sv
package pba_pkg;

    localparam int PKT_NUM_W = 7;

    typedef logic [PKT_NUM_W-1:0] pkt_num_t;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_ALLOC    = 3'd1,
        OP_RESET    = 3'd2,
        OP_RX_DROP  = 3'd3,
        OP_RX_FREE  = 3'd4,
        OP_FREE     = 3'd5,
        OP_TX_ENQ   = 3'd6,
        OP_TX_RESET = 3'd7
    } pba_op_e;

    typedef struct packed {
        pba_op_e    op;
        logic [4:0] arg;
    } pba_cmd_t;

    typedef struct packed {
        logic     fail;
        pkt_num_t num;
    } alloc_res_t;

    function automatic pba_cmd_t pba_decode(input logic [7:0] w);
        pba_cmd_t c;
        c.op  = pba_op_e'(w[7:5]);
        c.arg = w[4:0];
        return c;
    endfunction

    function automatic logic pba_is_release(input pba_op_e op);
        return (op == OP_RX_FREE) || (op == OP_FREE);
    endfunction

endpackage

// File: rtl/pba_pkt_fifo.sv
module pba_pkt_fifo
    import pba_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     push,
    input  pkt_num_t push_data,
    input  logic     pop,
    output pkt_num_t head,
    output logic     empty
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    pkt_num_t      mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [AW:0]   count;
    logic          pop_ok;
    logic          push_ok;

    assign empty   = (count == '0);
    assign pop_ok  = pop && !empty;
    assign push_ok = push && ((count != FULL_CNT) || pop_ok);
    assign head    = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                mem[wr_ptr] <= push_data;
                wr_ptr      <= wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (count == FULL_CNT) && push && !pop && !clr |=> (count == FULL_CNT)); // R6

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT); // R6

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr |=> empty); // R10

endmodule

// File: rtl/pba_page_pool.sv
module pba_page_pool
    import pba_pkg::*;
#(
    parameter int NUM_PAGES = 12,
    parameter int NUM_PKTS  = 4,
    parameter int REQ_W     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             alloc_req,
    input  logic [REQ_W-1:0] alloc_pages_m1,
    input  logic             free_req,
    input  pkt_num_t         free_pkt,
    output logic             alloc_done,
    output alloc_res_t       alloc_res,
    output logic [7:0]       free_pages
);
    localparam int PG_W = $clog2(NUM_PAGES + 1);
    localparam int CW   = (PG_W > REQ_W) ? PG_W : REQ_W + 1;
    localparam int SW   = $clog2(NUM_PKTS);
    localparam pkt_num_t PKT_LIMIT = pkt_num_t'(NUM_PKTS);

    logic [NUM_PKTS-1:0] used;
    logic [CW-1:0]       pages [NUM_PKTS];
    logic [CW-1:0]       free_cnt;
    logic [CW-1:0]       req;
    logic [SW-1:0]       slot;
    logic                found;
    logic                grant;
    logic [SW-1:0]       fidx;
    logic                free_hit;
    logic [CW-1:0]       give_back;
    logic [CW-1:0]       take;

    always_comb begin
        found = 1'b0;
        slot  = '0;
        for (int i = NUM_PKTS - 1; i >= 0; i--) begin
            if (!used[i]) begin
                found = 1'b1;
                slot  = SW'(i);
            end
        end
    end

    assign req       = CW'(alloc_pages_m1) + 1'b1;
    assign grant     = alloc_req && found && (free_cnt >= req);
    assign fidx      = free_pkt[SW-1:0];
    assign free_hit  = free_req && (free_pkt < PKT_LIMIT) && used[fidx];
    assign give_back = free_hit ? pages[fidx] : '0;
    assign take      = grant ? req : '0;
    assign free_pages = 8'(free_cnt);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            used       <= '0;
            free_cnt   <= CW'(NUM_PAGES);
            alloc_res  <= '0;
            alloc_done <= 1'b0;
        end else begin
            alloc_done <= alloc_req;
            if (alloc_req) begin
                if (grant) begin
                    used[slot]  <= 1'b1;
                    pages[slot] <= req;
                    alloc_res   <= '{fail: 1'b0, num: pkt_num_t'(slot)};
                end else begin
                    alloc_res   <= '{fail: 1'b1, num: '0};
                end
            end
            if (free_hit) begin
                used[fidx] <= 1'b0;
            end
            free_cnt <= free_cnt - take + give_back;
        end
    end

    AST_FREE_BOUND: assert property (@(posedge clk) disable iff (rst)
        free_cnt <= CW'(NUM_PAGES)); // R4

    AST_FAIL_KEEPS_POOL: assert property (@(posedge clk) disable iff (rst)
        alloc_done && alloc_res.fail |-> free_cnt == $past(free_cnt)); // R3

    AST_GRANT_SLOT_USED: assert property (@(posedge clk) disable iff (rst)
        alloc_done && !alloc_res.fail |-> used[alloc_res.num[SW-1:0]]); // R2

endmodule

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc
    import pba_pkg::*;
#(
    parameter int NUM_PAGES  = 12,
    parameter int NUM_PKTS   = 4,
    parameter int Q_DEPTH    = 4,
    parameter int REQ_W      = 4,
    parameter int REL_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [7:0]  cmd_word,
    input  logic [6:0]  pkt_sel,
    output logic [7:0]  cmd_status,
    output logic [7:0]  alloc_result,
    output logic        alloc_done,
    output logic [15:0] queue_view,
    output logic [15:0] mem_info,
    input  logic        rx_done_valid,
    input  logic [6:0]  rx_done_pkt,
    input  logic        tx_done
);
    localparam int BW = $clog2(REL_CYCLES + 1);

    pba_cmd_t   cmd;
    logic       accept;
    logic       busy;
    logic [BW-1:0] busy_cnt;
    pkt_num_t   rx_head;
    pkt_num_t   tx_head;
    logic       rx_empty;
    logic       tx_empty;
    logic       pool_clr;
    logic       rx_pop;
    logic       tx_push;
    logic       tx_clr;
    logic       free_req;
    pkt_num_t   free_pkt;
    alloc_res_t res;
    logic [7:0] free_pages;

    assign cmd    = pba_decode(cmd_word);
    assign busy   = (busy_cnt != '0);
    assign accept = cmd_valid && !busy;

    assign pool_clr = accept && (cmd.op == OP_RESET);
    assign rx_pop   = accept && ((cmd.op == OP_RX_DROP) || (cmd.op == OP_RX_FREE));
    assign tx_push  = accept && (cmd.op == OP_TX_ENQ);
    assign tx_clr   = accept && ((cmd.op == OP_RESET) || (cmd.op == OP_TX_RESET));
    assign free_req = accept && (((cmd.op == OP_RX_FREE) && !rx_empty) || (cmd.op == OP_FREE));
    assign free_pkt = (cmd.op == OP_RX_FREE) ? rx_head : pkt_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_cnt <= '0;
        end else if (accept && pba_is_release(cmd.op)) begin
            busy_cnt <= BW'(REL_CYCLES);
        end else if (busy) begin
            busy_cnt <= busy_cnt - 1'b1;
        end
    end

    pba_pkt_fifo #(.DEPTH(Q_DEPTH)) u_rxq (
        .clk       (clk),
        .rst       (rst),
        .clr       (pool_clr),
        .push      (rx_done_valid),
        .push_data (rx_done_pkt),
        .pop       (rx_pop),
        .head      (rx_head),
        .empty     (rx_empty)
    );

    pba_pkt_fifo #(.DEPTH(Q_DEPTH)) u_txq (
        .clk       (clk),
        .rst       (rst),
        .clr       (tx_clr),
        .push      (tx_push),
        .push_data (pkt_sel),
        .pop       (tx_done),
        .head      (tx_head),
        .empty     (tx_empty)
    );

    pba_page_pool #(
        .NUM_PAGES (NUM_PAGES),
        .NUM_PKTS  (NUM_PKTS),
        .REQ_W     (REQ_W)
    ) u_pool (
        .clk            (clk),
        .rst            (rst),
        .clr            (pool_clr),
        .alloc_req      (accept && (cmd.op == OP_ALLOC)),
        .alloc_pages_m1 (cmd.arg[REQ_W-1:0]),
        .free_req       (free_req),
        .free_pkt       (free_pkt),
        .alloc_done     (alloc_done),
        .alloc_res      (res),
        .free_pages     (free_pages)
    );

    assign alloc_result = res;
    assign cmd_status   = {7'b0, busy};
    assign queue_view   = {rx_empty, rx_head, tx_empty, tx_head};
    assign mem_info     = {free_pages, 8'(NUM_PAGES)};

    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
        busy && cmd_valid |=> $stable(mem_info) && !alloc_done); // R9

    AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cmd_valid)); // R9

    AST_ALLOC_ANSWERS: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !busy && (cmd_word[7:5] == 3'd1) |=> alloc_done); // R2

    AST_RESET_CMD: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !busy && (cmd_word[7:5] == 3'd2)
        |=> (mem_info[15:8] == 8'(NUM_PAGES)) && (queue_view == 16'h8080) && !alloc_result[7]); // R11

endmodule

// File: tb/sim_pkt_page_alloc.sv
module sim_pkt_page_alloc;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_word = '0;
    logic [6:0]  pkt_sel = '0;
    logic [7:0]  cmd_status;
    logic [7:0]  alloc_result;
    logic        alloc_done;
    logic [15:0] queue_view;
    logic [15:0] mem_info;
    logic        rx_done_valid = 1'b0;
    logic [6:0]  rx_done_pkt = '0;
    logic        tx_done = 1'b0;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #2 clk = ~clk;

    pkt_page_alloc u0 (
        .clk           (clk),
        .rst           (rst),
        .cmd_valid     (cmd_valid),
        .cmd_word      (cmd_word),
        .pkt_sel       (pkt_sel),
        .cmd_status    (cmd_status),
        .alloc_result  (alloc_result),
        .alloc_done    (alloc_done),
        .queue_view    (queue_view),
        .mem_info      (mem_info),
        .rx_done_valid (rx_done_valid),
        .rx_done_pkt   (rx_done_pkt),
        .tx_done       (tx_done)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [7:0] w, input logic [6:0] sel);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        pkt_sel   = sel;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic do_alloc(input logic [7:0] w, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        issue(w, '0);
    endtask

    task automatic rx_push(input logic [6:0] p);
        @(negedge clk);
        rx_done_valid = 1'b1;
        rx_done_pkt   = p;
        @(negedge clk);
        rx_done_valid = 1'b0;
    endtask

    task automatic tx_pop;
        @(negedge clk);
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
    endtask

    task automatic wait_idle;
        while (cmd_status[0]) @(negedge clk);
    endtask

    // scoreboard monitor for allocation answers
    always @(negedge clk) begin
        if (!rst && alloc_done) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R9 unexpected alloc_done actual=0x%0h expected=none", alloc_result);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (alloc_result !== e) begin
                    failures++;
                    $display("FAIL %s alloc_result actual=0x%0h expected=0x%0h", t, alloc_result, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 mem_info", mem_info, 32'h0C0C);
        check("R1 queue_view", queue_view, 32'h8080);
        check("R1 alloc_result", alloc_result, 32'h00);
        check("R1 busy", cmd_status, 32'h00);

        // R4: 16-page request exceeds the whole pool
        do_alloc(8'h2F, 8'h80, "R4 oversize");
        check("R4 free unchanged", mem_info, 32'h0C0C);

        // R2 grants in slot order
        do_alloc(8'h22, 8'h00, "R2 alloc 3");
        check("R2 free 9", mem_info, 32'h090C);
        do_alloc(8'h24, 8'h01, "R2 alloc 5");
        check("R2 free 4", mem_info, 32'h040C);
        // R3 page shortage
        do_alloc(8'h24, 8'h80, "R3 short pages");
        check("R3 free kept", mem_info, 32'h040C);
        do_alloc(8'h23, 8'h02, "R2 exact fit");
        check("R2 free 0", mem_info, 32'h000C);

        // R5 / R6 transmit queue
        issue(8'hC0, 7'd1);
        check("R5 tx head 1", queue_view, 32'h8001);
        issue(8'hC0, 7'd2);
        check("R6 head kept", queue_view, 32'h8001);
        tx_pop();
        check("R6 pop to 2", queue_view, 32'h8002);
        tx_pop();
        check("R5 tx empty", queue_view, 32'h8080);

        // R7 receive queue
        rx_push(7'd0);
        check("R7 rx head 0", queue_view, 32'h0080);
        rx_push(7'd2);
        check("R7 rx head kept", queue_view, 32'h0080);
        issue(8'h60, '0);
        check("R7 drop head", queue_view, 32'h0280);
        check("R7 no pages back", mem_info, 32'h000C);

        // R8 / R9 release of receive head
        issue(8'h80, '0);
        check("R8 rx empty", queue_view, 32'h8080);
        check("R8 pages back", mem_info, 32'h040C);
        check("R9 busy high", cmd_status, 32'h01);
        issue(8'h20, '0);
        check("R9 ignored alloc", mem_info, 32'h040C);
        check("R9 still busy", cmd_status, 32'h01);
        wait_idle();

        issue(8'hA0, 7'd0);
        check("R8 free named", mem_info, 32'h070C);
        wait_idle();
        issue(8'hA0, 7'd0);
        check("R8 double free", mem_info, 32'h070C);
        wait_idle();

        // R3 slot exhaustion
        do_alloc(8'h20, 8'h00, "R2 reuse slot 0");
        do_alloc(8'h20, 8'h02, "R2 reuse slot 2");
        do_alloc(8'h20, 8'h03, "R2 slot 3");
        check("R2 free 4", mem_info, 32'h040C);
        do_alloc(8'h20, 8'h80, "R3 no slot");
        check("R3 free kept", mem_info, 32'h040C);

        // R6 overflow
        issue(8'hC0, 7'd3);
        issue(8'hC0, 7'd2);
        issue(8'hC0, 7'd1);
        issue(8'hC0, 7'd0);
        issue(8'hC0, 7'd3);
        check("R6 fifo head 3", queue_view, 32'h8003);
        tx_pop();
        check("R6 order 2", queue_view, 32'h8002);
        tx_pop();
        check("R6 order 1", queue_view, 32'h8001);
        tx_pop();
        check("R6 order 0", queue_view, 32'h8000);
        tx_pop();
        check("R6 overflow dropped", queue_view, 32'h8080);

        // R10 transmit reset
        issue(8'hC0, 7'd1);
        rx_push(7'd3);
        check("R10 before", queue_view, 32'h0301);
        issue(8'hE0, '0);
        check("R10 tx cleared", queue_view, 32'h0380);
        check("R10 pool kept", mem_info, 32'h040C);

        // R12 no-op
        issue(8'h00, '0);
        check("R12 view", queue_view, 32'h0380);
        check("R12 mem", mem_info, 32'h040C);
        check("R12 result", alloc_result, 32'h80);

        // R11 full reset
        issue(8'h40, '0);
        check("R11 mem", mem_info, 32'h0C0C);
        check("R11 view", queue_view, 32'h8080);
        check("R11 result", alloc_result, 32'h00);
        do_alloc(8'h2B, 8'h00, "R11 whole pool");
        check("R11 drained", mem_info, 32'h000C);

        repeat (2) @(negedge clk);
        check("R2 scoreboard drained", exp_q.size(), 32'd0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule